// File: doc/BRIEF.md
# Dual-Counter Interval Timer with Compare Channels

This block is a 16-bit timer unit with two independent up-counters. Each counter advances on its own prescaled tick, taken from the system clock divided by a power of two between 1 and 128. Each counter has a period register. When match-and-clear is enabled for a counter, the counter returns to zero on the tick after it reaches its period, so it runs as an interval timer.

Four general compare channels watch the counters. Each channel chooses one of the two counters with a select bit. It raises a single-cycle interrupt whenever that counter reaches the channel's compare value. Each period register also raises its own single-cycle interrupt on a match.

Software configures the block through a write-only port: a 3-bit address, 16-bit data and a write strobe. Every write takes effect on the next clock edge.

Top module: `dtmr_top`

## Requirements
- R1: After reset, every interrupt output is low and both counters are stopped at zero.
- R2: A counter runs only while the global enable (control bit 0) and its own enable (control bit 1 for counter 0, bit 2 for counter 1) are both set. Otherwise it produces no interrupts.
- R3: A counter's 3-bit clock select value s (control bits [5:3] for counter 0, [8:6] for counter 1) divides the system clock by 2^s. Counter value k is reached k·2^s cycles after the write that starts it.
- R4: When the counter's clear bit is set (mode bit 4 for counter 0, bit 5 for counter 1), the counter goes to zero on the tick after it equals its period register P. Matches then repeat every (P+1)·2^s cycles.
- R5: Period interrupt j (irq_per[j]) pulses each time counter j reaches the value in period register j. It does so whether or not clearing is enabled.
- R6: When compare channel i has its mode bit set (mode bit i), irq_cmp[i] pulses each time its selected counter equals compare register i. The selected counter is the one named by control bit 9+i: 0 picks counter 0 and 1 picks counter 1.
- R7: A compare channel whose mode bit is clear never pulses, whatever its counter and compare value.
- R8: Each interrupt is high for exactly one clock per match. It rises one cycle after the counter takes the matching value.
- R9: A write to a compare or period register changes which value is matched from the next cycle, while the counter keeps running.
- R10: Clearing an enable bit stops the counter and sets it to zero. A later start counts again from zero.
- R11: Register addresses are: 0 control, 1 mode, 2 and 3 period of counters 0 and 1, 4 to 7 compare channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| irq_cmp | output | 4 | One-cycle match pulse per compare channel |
| irq_per | output | 2 | One-cycle match pulse per period register |

## Verification
A counter started by a write latched at edge W holds value k after edge W+k·2^s. The interrupt for that value is visible one edge later, at W+k·2^s+1. With clearing enabled, each later match comes (P+1)·2^s cycles after the previous one.

The driver records W for every start and retargeting write and pushes the exact due cycle of every pulse into a per-source queue. The monitor samples on the falling edge. It accepts a pulse only in the cycle at the front of its queue, and it reports a pulse that is early, late, missing or unrequested. Stop writes are timed so that no expected pulse falls on the stopping edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned N_CTR  = 2;
  localparam int unsigned N_CMP  = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned ADDR_W = 3;

  // control register layout
  localparam int unsigned CTL_GEN     = 0;
  localparam int unsigned CTL_EN_LSB  = 1;
  localparam int unsigned CTL_SEL_LSB = CTL_EN_LSB + N_CTR;
  localparam int unsigned CTL_ASG_LSB = CTL_SEL_LSB + N_CTR * SEL_W;
  localparam int unsigned CTL_W       = CTL_ASG_LSB + N_CMP;

  // mode register layout
  localparam int unsigned MODE_CMP_LSB = 0;
  localparam int unsigned MODE_CLR_LSB = N_CMP;
  localparam int unsigned MODE_W       = MODE_CLR_LSB + N_CTR;

  // address map
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_MODE = 1;
  localparam int unsigned ADR_PER  = 2;
  localparam int unsigned ADR_CMP  = ADR_PER + N_CTR;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned NC = N_CTR,
  parameter int unsigned NM = N_CMP,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  output logic                   glb_en,
  output logic [NC-1:0]          ctr_en,
  output logic [NC-1:0][SW-1:0]  clk_sel,
  output logic [NC-1:0]          clr_on,
  output logic [NM-1:0]          ch_ctr,
  output logic [NM-1:0]          ch_on,
  output logic [NC-1:0][CW-1:0]  period,
  output logic [NM-1:0][CW-1:0]  cmp_val
);
  localparam int unsigned CTW = CTL_W;
  localparam int unsigned MDW = MODE_W;

  logic [CTW-1:0]         ctrl_q, ctrl_d;
  logic [MDW-1:0]         mode_q, mode_d;
  logic [NC-1:0][CW-1:0]  per_q,  per_d;
  logic [NM-1:0][CW-1:0]  cmp_q,  cmp_d;

  always_comb begin
    ctrl_d = ctrl_q;
    mode_d = mode_q;
    per_d  = per_q;
    cmp_d  = cmp_q;
    if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL)) ctrl_d = wr_data[CTW-1:0];
      if (wr_addr == AW'(ADR_MODE)) mode_d = wr_data[MDW-1:0];
      for (int j = 0; j < NC; j++)
        if (wr_addr == AW'(ADR_PER + j)) per_d[j] = wr_data;
      for (int i = 0; i < NM; i++)
        if (wr_addr == AW'(ADR_CMP + i)) cmp_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      per_q  <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      per_q  <= per_d;
      cmp_q  <= cmp_d;
    end
  end

  assign glb_en  = ctrl_q[CTL_GEN];
  assign period  = per_q;
  assign cmp_val = cmp_q;

  for (genvar j = 0; j < NC; j++) begin : g_ctr_fields
    assign ctr_en[j]  = ctrl_q[CTL_EN_LSB + j];
    assign clk_sel[j] = ctrl_q[CTL_SEL_LSB + j * SW +: SW];
    assign clr_on[j]  = mode_q[MODE_CLR_LSB + j];
  end

  for (genvar i = 0; i < NM; i++) begin : g_ch_fields
    assign ch_ctr[i] = ctrl_q[CTL_ASG_LSB + i];
    assign ch_on[i]  = mode_q[MODE_CMP_LSB + i];
  end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int unsigned CW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel,
  input  logic [CW-1:0] period,
  input  logic          clr_on,
  output logic [CW-1:0] cnt
);
  localparam int unsigned PW = (1 << SW) - 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW:0]   span;
  logic [PW-1:0] mask;
  logic          tick;
  logic          wrap;

  always_comb begin
    span  = ({{PW{1'b0}}, 1'b1} << sel) - 1'b1;
    mask  = span[PW-1:0];
    tick  = run && ((pre_q & mask) == mask);
    wrap  = clr_on && (cnt_q == period);
    pre_d = run ? pre_q + 1'b1 : '0;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dtmr_pulse.sv
module dtmr_pulse #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  output logic [N-1:0] pulse
);
  logic [N-1:0] hit_q;
  logic [N-1:0] pulse_q, pulse_d;

  always_comb pulse_d = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      pulse_q <= '0;
    end else begin
      hit_q   <= hit;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned NC = N_CTR,
  parameter int unsigned NM = N_CMP,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [NM-1:0] irq_cmp,
  output logic [NC-1:0] irq_per
);
  localparam int unsigned NSRC = NM + NC;

  logic                  glb_en;
  logic [NC-1:0]         ctr_en;
  logic [NC-1:0][SW-1:0] clk_sel;
  logic [NC-1:0]         clr_on;
  logic [NM-1:0]         ch_ctr;
  logic [NM-1:0]         ch_on;
  logic [NC-1:0][CW-1:0] period;
  logic [NM-1:0][CW-1:0] cmp_val;
  logic [NC-1:0]         run;
  logic [NC-1:0][CW-1:0] cnt;
  logic [NSRC-1:0]       hit;
  logic [NSRC-1:0]       pulse;

  dtmr_regs #(.CW(CW), .NC(NC), .NM(NM), .SW(SW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .glb_en  (glb_en),
    .ctr_en  (ctr_en),
    .clk_sel (clk_sel),
    .clr_on  (clr_on),
    .ch_ctr  (ch_ctr),
    .ch_on   (ch_on),
    .period  (period),
    .cmp_val (cmp_val)
  );

  for (genvar j = 0; j < NC; j++) begin : g_ctr
    assign run[j] = glb_en && ctr_en[j];

    dtmr_counter #(.CW(CW), .SW(SW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run[j]),
      .sel    (clk_sel[j]),
      .period (period[j]),
      .clr_on (clr_on[j]),
      .cnt    (cnt[j])
    );

    assign hit[NM + j] = run[j] && (cnt[j] == period[j]);
  end

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    assign hit[i] = ch_on[i] && run[ch_ctr[i]] && (cnt[ch_ctr[i]] == cmp_val[i]);
  end

  dtmr_pulse #(.N(NSRC)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .pulse (pulse)
  );

  assign irq_cmp = pulse[NM-1:0];
  assign irq_per = pulse[NM +: NC];
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int unsigned CW = 16,
  parameter int unsigned NC = 2,
  parameter int unsigned NM = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NM-1:0]         irq_cmp,
  input logic [NC-1:0]         irq_per,
  input logic [NC-1:0]         run,
  input logic [NC-1:0][CW-1:0] cnt,
  input logic [NM-1:0]         ch_on
);
  logic [NM+NC-1:0] irq_all;
  assign irq_all = {irq_per, irq_cmp};

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run == '0) |=> (irq_all == '0));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_all != '0) |=> ((irq_all & $past(irq_all)) == '0));

  for (genvar j = 0; j < NC; j++) begin : g_ctr_chk
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run[j] && $past(run[j]) && (cnt[j] != $past(cnt[j])))
        |-> ((cnt[j] == CW'($past(cnt[j]) + 1'b1)) || (cnt[j] == '0)));

    // R10
    stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run[j] |=> (cnt[j] == '0));
  end

  for (genvar i = 0; i < NM; i++) begin : g_ch_chk
    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_on[i] |=> !irq_cmp[i]);
  end
endmodule

bind dtmr_top dtmr_chk #(.CW(CW), .NC(NC), .NM(NM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_cmp (irq_cmp),
  .irq_per (irq_per),
  .run     (run),
  .cnt     (cnt),
  .ch_on   (ch_on)
);

// File: tb/dtmr_top_test.sv
module dtmr_top_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  irq_cmp;
  logic [1:0]  irq_per;
  logic [5:0]  irq_all;

  typedef struct { int at; string tag; } exp_t;
  exp_t q [6][$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int npulse = 0;
  int last_w = 0;
  bit done = 0;

  dtmr_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_cmp(irq_cmp), .irq_per(irq_per)
  );

  assign irq_all = {irq_per, irq_cmp};

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // sources 0..3 compare channels, 4..5 period registers
  task automatic chk(input bit ok, input string tag, input int act, input int exp_v, input int src);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s source %0d: actual %0d expected %0d", tag, src, act, exp_v);
    end
  endtask

  function automatic logic [15:0] ctl(input bit g, input bit e0, input bit e1,
                                      input int s0, input int s1, input logic [3:0] asg);
    return 16'(g) | (16'(e0) << 1) | (16'(e1) << 2) | (16'(s0) << 3) |
           (16'(s1) << 6) | (16'(asg) << 9);
  endfunction

  function automatic logic [15:0] mde(input logic [3:0] cmp_on, input logic [1:0] clr);
    return 16'(cmp_on) | (16'(clr) << 4);
  endfunction

  task automatic push(input int src, input int first, input int step, input int stop, input string tag);
    for (int t = first; t <= stop; t += (step > 0 ? step : stop + 1)) q[src].push_back('{t, tag});
  endtask

  // called at a falling edge; latches at the next rising edge
  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk); #1 last_w = cyc;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expected pulse cycles per source
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int s = 0; s < 6; s++) begin
        exp_t e;
        if (irq_all[s]) begin
          npulse++;
          if (q[s].size() == 0) begin
            checks++; fails++;
            $display("FAIL R7 source %0d: actual pulse at %0d expected none", s, cyc);
          end else begin
            e = q[s].pop_front();
            chk(e.at == cyc, e.tag, cyc, e.at, s);
          end
        end else if (q[s].size() > 0 && q[s][0].at < cyc) begin
          e = q[s].pop_front();
          chk(1'b0, e.tag, -1, e.at, s);
        end
      end
    end
  end

  task automatic summary;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int w;
    int base;
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(irq_all == '0, "R1", int'(irq_all), 0, -1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(irq_all == '0, "R1", int'(irq_all), 0, -1);

    // T1: counter 0, divide by 1, period 9, clear on (R11 address map used throughout)
    wr(2, 16'd9); wr(4, 16'd3); wr(5, 16'd9);
    wr(1, mde(4'b0011, 2'b01));
    wr(0, ctl(1, 1, 0, 0, 0, 4'b0000));
    w = last_w;
    push(0, w + 4,  10, w + 35, "R6");
    push(1, w + 10, 10, w + 35, "R4");
    push(4, w + 10, 10, w + 35, "R5");
    wait_until(w + 34); wr(0, 16'd0);
    repeat (5) @(negedge clk);

    // T2: counter 1 divide by 4, channels 2/3 on counter 1, channels 0/1 mode off
    wr(3, 16'd5); wr(6, 16'd2); wr(7, 16'd5);
    wr(1, mde(4'b1100, 2'b11));
    wr(0, ctl(1, 1, 1, 0, 2, 4'b1100));
    w = last_w;
    push(2, w + 9,  24, w + 55, "R3");
    push(3, w + 21, 24, w + 55, "R6");
    push(5, w + 21, 24, w + 55, "R4");
    push(4, w + 10, 10, w + 55, "R5");
    wait_until(w + 54); wr(0, 16'd0);
    repeat (5) @(negedge clk);

    // T3: global enable off, then per-counter enables off
    wr(1, mde(4'b1111, 2'b11));
    base = npulse;
    wr(0, ctl(0, 1, 1, 0, 0, 4'b0000));
    repeat (40) @(negedge clk);
    chk(npulse == base, "R2", npulse - base, 0, -1);
    wr(0, ctl(1, 0, 0, 0, 0, 4'b0000));
    repeat (40) @(negedge clk);
    chk(npulse == base, "R2", npulse - base, 0, -1);
    wr(0, 16'd0);
    repeat (3) @(negedge clk);

    // T4: clear off, restart from zero after earlier runs
    wr(2, 16'd4); wr(4, 16'd6);
    wr(1, mde(4'b0001, 2'b00));
    wr(0, ctl(1, 1, 0, 0, 0, 4'b0000));
    w = last_w;
    push(4, w + 5, 0, w + 30, "R5");
    push(0, w + 7, 0, w + 30, "R10");
    wait_until(w + 29); wr(0, 16'd0);
    repeat (3) @(negedge clk);

    // T5: counter 1 divide by 128, period 3
    wr(3, 16'd3); wr(6, 16'd1);
    wr(1, mde(4'b0100, 2'b10));
    wr(0, ctl(1, 0, 1, 0, 7, 4'b0100));
    w = last_w;
    push(2, w + 129, 512, w + 700, "R3");
    push(5, w + 385, 512, w + 700, "R4");
    wait_until(w + 699); wr(0, 16'd0);
    repeat (3) @(negedge clk);

    // T6: compare value rewritten while running
    wr(2, 16'd19); wr(4, 16'd5);
    wr(1, mde(4'b0001, 2'b01));
    wr(0, ctl(1, 1, 0, 0, 0, 4'b0000));
    w = last_w;
    push(0, w + 6,  20, w + 26, "R6");
    push(4, w + 20, 20, w + 57, "R5");
    wait_until(w + 29); wr(4, 16'd12);
    push(0, w + 33, 20, w + 57, "R9");
    wait_until(w + 57); wr(0, 16'd0);
    repeat (5) @(negedge clk);

    for (int s = 0; s < 6; s++) chk(q[s].size() == 0, "R8", q[s].size(), 0, s);
    summary();
  end
endmodule